// File: doc/BRIEF.md
# Reset Source Sequencer

This block merges the reset requests of a small microcontroller into one internal reset line. Three sources feed it: a power-on indication, an active-low external reset pin and a timeout strobe from the watchdog. The power-on indication clears the block asynchronously. The pin level goes through a two-flop synchronizer. A rising edge of the watchdog strobe becomes a pulse exactly one crystal-clock cycle wide.

Each active source keeps the internal reset asserted. When the last source lets go, a delay counter holds the reset asserted for a fixed number of crystal-clock cycles. For the pin, the count starts when the synchronized level goes high again. For the watchdog, it starts when the one-cycle pulse ends. Any new request during the count sends the counter back to zero. A three-bit cause register shows which sources have fired since software last cleared them. Software clears a bit by writing 1 to it.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high, `rst_o` is 1 and `cause_o` is 3'b001. Bit 0 is power-on, bit 1 is external pin and bit 2 is watchdog.
- R2: Suppose `por_i` falls between two clock edges while the pin is high and the strobe is low. Then `rst_o` stays 1 through the first TOUT_CYC-1 rising edges after the release. It reads 0 after edge TOUT_CYC.
- R3: Suppose `ext_rst_n_i` goes low just after edge 0. Then `rst_o` reads 0 after edge 2, as long as it was idle. It reads 1 after edge 3 and stays 1 while the pin is low.
- R4: Suppose the pin goes back high just after edge L. Then `rst_o` stays 1 through edge L+TOUT_CYC+1 and reads 0 after edge L+TOUT_CYC+2.
- R5: If the pin is low when `por_i` releases, the reset lasts beyond TOUT_CYC cycles. It then ends as set out in R4, counted from the pin release.
- R6: Suppose `wdt_tmo_i` rises just after edge 0. Then `rst_o` reads 0 after edge 1, as long as it was idle, and 1 after edge 2. It reads 0 after edge TOUT_CYC+2.
- R7: The watchdog pulse is one cycle long however long the strobe stays high. Holding the strobe high for several cycles gives the same release edge as a one-cycle strobe.
- R8: A new request that arrives while the delay counter runs restarts the full time-out. For example, a second strobe rise just after edge 6 moves the release to edge 6+TOUT_CYC+2.
- R9: A synchronized low pin level sets `cause_o[1]`. A watchdog pulse sets `cause_o[2]`. Each bit stays set until it is cleared.
- R10: A 1 on bit i of `cause_clr_i` during one clock cycle clears `cause_o[i]` at the next edge. A 0 bit has no effect. If a set and a clear reach the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| por_i | input | 1 | Power-on reset indication, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin level, active low, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog timeout strobe; its rising edge requests a reset |
| cause_clr_i | input | 3 | Write-1-to-clear strobes for the cause bits |
| rst_o | output | 1 | Internal reset, active high |
| cause_o | output | 3 | Reset cause flags: bit 0 power-on, bit 1 pin, bit 2 watchdog |

## Verification
If the delay counter is off by one, or fails to go back to zero on a request, the release edge of `rst_o` moves. That shift shows up one edge after the expected fall, or only after the full time-out in the restart case. A wrong synchronizer depth or a stretched watchdog pulse moves both the rise and the fall of `rst_o` by whole cycles, and the bench measures both. A cause bit stuck at a wrong value, or a clear winning over a set, shows on `cause_o` one edge after the stimulus.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    localparam int CAUSE_W   = 3;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_WDT = 2;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_RST = cause_t'(1) << CAUSE_POR;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stg = {st_q.stg[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '{stg: {STAGES{RST_VAL}}};
        else        st_q <= st_d;
    end

    assign q_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/rstseq_wdt_pulse.sv
module rstseq_wdt_pulse (
    input  logic clk_i,
    input  logic arst_i,
    input  logic strobe_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } wp_st_t;

    wp_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = strobe_i;
        st_d.pulse = strobe_i & ~st_q.prev;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '{prev: 1'b0, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
    parameter int TOUT_CYC = 75
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic hold_i,
    output logic busy_o
);
    localparam int CNT_W = (TOUT_CYC > 2) ? $clog2(TOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOUT_CYC - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } dl_st_t;

    dl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '{run: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign busy_o = st_q.run;

    // R8
    hold_restart_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        hold_i |=> (busy_o && st_q.cnt == '0));

    // R4
    timeout_release_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (!hold_i && busy_o && st_q.cnt == CNT_LAST) |=> !busy_o);

    // R2
    idle_stays_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (!hold_i && !busy_o) |=> !busy_o);

    // R2
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        int'(st_q.cnt) < TOUT_CYC);
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic   clk_i,
    input  logic   arst_i,
    input  cause_t set_i,
    input  cause_t clr_i,
    output cause_t cause_o
);
    typedef struct packed {
        cause_t flags;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CAUSE_W; i++) begin
            if (set_i[i])      st_d.flags[i] = 1'b1;
            else if (clr_i[i]) st_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '{flags: CAUSE_RST};
        else        st_q <= st_d;
    end

    assign cause_o = st_q.flags;

    // R9
    cause_set_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i)));

    // R10
    cause_clear_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        ((clr_i & ~set_i) != '0) |=> ((cause_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int TOUT_CYC    = 75,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               por_i,
    input  logic               ext_rst_n_i,
    input  logic               wdt_tmo_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    output logic               rst_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic   pin_s;
    logic   wdt_pulse;
    logic   hold;
    logic   busy;
    cause_t cause_set;

    rstseq_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) pin_sync_i (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .d_i    (ext_rst_n_i),
        .q_o    (pin_s)
    );

    rstseq_wdt_pulse wdt_pulse_i (
        .clk_i    (clk_i),
        .arst_i   (por_i),
        .strobe_i (wdt_tmo_i),
        .pulse_o  (wdt_pulse)
    );

    always_comb begin
        hold                 = ~pin_s | wdt_pulse;
        cause_set            = '0;
        cause_set[CAUSE_EXT] = ~pin_s;
        cause_set[CAUSE_WDT] = wdt_pulse;
    end

    rstseq_delay #(
        .TOUT_CYC (TOUT_CYC)
    ) delay_i (
        .clk_i  (clk_i),
        .arst_i (por_i),
        .hold_i (hold),
        .busy_o (busy)
    );

    rstseq_cause cause_i (
        .clk_i   (clk_i),
        .arst_i  (por_i),
        .set_i   (cause_set),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

    assign rst_o = busy;

    // R6
    wdt_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_pulse |=> rst_o);

    // R3
    pin_low_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !pin_s |=> (rst_o && cause_o[CAUSE_EXT]));
endmodule

// File: tb/reset_sequencer_tb_top.sv
module reset_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TOUT       = 12;

    logic       clk = 1'b0;
    logic       por;
    logic       pin_n;
    logic       wdt;
    logic [2:0] clr;
    logic       rst;
    logic [2:0] cause;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_sequencer #(.TOUT_CYC(TOUT), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk),
        .por_i       (por),
        .ext_rst_n_i (pin_n),
        .wdt_tmo_i   (wdt),
        .cause_clr_i (clr),
        .rst_o       (rst),
        .cause_o     (cause)
    );

    typedef struct packed {
        logic [7:0] is_wdt;
        logic [7:0] len;
        logic [7:0] rise;
        logic [7:0] fall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0, 8'd1, 8'd3, 8'(1 + TOUT + 2)},
        '{8'd0, 8'd4, 8'd3, 8'(4 + TOUT + 2)},
        '{8'd0, 8'd9, 8'd3, 8'(9 + TOUT + 2)},
        '{8'd1, 8'd1, 8'd2, 8'(TOUT + 2)},
        '{8'd1, 8'd3, 8'd2, 8'(TOUT + 2)},
        '{8'd1, 8'd6, 8'd2, 8'(TOUT + 2)}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_cause(input logic [2:0] bits);
        clr = bits;
        step(1);
        clr = 3'b000;
    endtask

    // Starts a request just after the current edge, ends it after edge len.
    task automatic run_vec(input logic is_wdt, input int len,
                           output int rise, output int fall);
        rise = 0;
        fall = 0;
        if (is_wdt) wdt = 1'b1; else pin_n = 1'b0;
        for (int n = 1; n < 200; n++) begin
            @(posedge clk);
            #1;
            if (rise == 0 && rst) rise = n;
            if (rise != 0 && fall == 0 && !rst) fall = n;
            if (n == len) begin
                wdt   = 1'b0;
                pin_n = 1'b1;
            end
            if (fall != 0) break;
        end
    endtask

    task automatic edges_to_fall(output int fall);
        fall = 0;
        for (int n = 1; n < 200; n++) begin
            @(posedge clk);
            #1;
            if (!rst) begin
                fall = n;
                break;
            end
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int r, f;
        por = 1'b1; pin_n = 1'b1; wdt = 1'b0; clr = 3'b000;
        step(3);
        // R1 reset state
        chk("R1 rst_o", int'(rst), 1);
        chk("R1 cause_o", int'(cause), 1);

        // R2 power-on release
        por = 1'b0;
        edges_to_fall(f);
        chk("R2 por release edge", f, TOUT);
        step(2);

        // R10 zero bits and clearing an already clear bit leave the register alone
        clear_cause(3'b010);
        step(1);
        chk("R10 clear of zero bit", int'(cause), 1);
        clear_cause(3'b001);
        step(1);
        chk("R10 clear por bit", int'(cause), 0);

        // Vector table: R3/R4 pin, R6/R7 watchdog, R9 cause bits
        for (int v = 0; v < NVEC; v++) begin
            run_vec(VECS[v].is_wdt[0], int'(VECS[v].len), r, f);
            if (VECS[v].is_wdt[0]) begin
                chk("R6 wdt rise edge", r, int'(VECS[v].rise));
                chk("R7 wdt fall edge", f, int'(VECS[v].fall));
                chk("R9 wdt cause", int'(cause), 4);
            end else begin
                chk("R3 pin rise edge", r, int'(VECS[v].rise));
                chk("R4 pin fall edge", f, int'(VECS[v].fall));
                chk("R9 pin cause", int'(cause), 2);
            end
            step(2);
            clear_cause(3'b111);
            step(1);
            chk("R10 clear all", int'(cause), 0);
        end

        // R8 retrigger: second strobe rise just after edge 6
        wdt = 1'b1;
        step(1);
        wdt = 1'b0;
        step(5);
        wdt = 1'b1;
        step(1);
        wdt = 1'b0;
        edges_to_fall(f);
        chk("R8 retrigger fall edge", f + 7, 6 + TOUT + 2);
        step(2);
        clear_cause(3'b111);

        // R10 set wins over a clear in the same cycle
        pin_n = 1'b0;
        step(4);
        clear_cause(3'b010);
        step(1);
        chk("R10 set beats clear", int'(cause[1]), 1);
        pin_n = 1'b1;
        edges_to_fall(f);
        chk("R4 fall after set-wins case", f, TOUT + 2);
        step(2);

        // R5 pin held low across power-on release
        por = 1'b1;
        pin_n = 1'b0;
        step(2);
        por = 1'b0;
        step(TOUT + 8);
        chk("R5 still in reset past TOUT", int'(rst), 1);
        chk("R5 cause por and pin", int'(cause), 3);
        pin_n = 1'b1;
        edges_to_fall(f);
        chk("R5 fall after pin release", f, TOUT + 2);

        finish_run();
    end
endmodule